// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This block sits beside a processor's execute stage and resolves conditional branches. A compare instruction does not compute flags here: it only records its two register operands in a pair of operand latches. A later conditional branch names one of ten relations. The block checks that relation between the stored first operand and the stored second operand, in that order, and returns the taken decision with the next program counter.

The signed and unsigned relations are worked out from the raw operands only when a branch is resolved, so a compare costs nothing beyond the latch write. Branch displacements come as a 10-bit two's-complement field counted in 16-bit instruction units. A branch whose condition code names no relation is reported as illegal, so the surrounding core can raise an exception at the branch's own address.

Top module: `cmp_branch_unit`

## Requirements
- R1: During and right after a synchronous active-low reset, both operand latches hold zero and `res_valid`, `res_taken`, `res_illegal` and `res_next_pc` are all zero.
- R2: A cycle with `cmp_valid` high stores `cmp_a` as the first operand and `cmp_b` as the second. A cycle with it low leaves both untouched. Every relation compares first against second.
- R3: Condition codes 0 to 9 select equal, not equal, signed less, signed greater, unsigned less, unsigned greater, signed greater-or-equal, signed less-or-equal, unsigned greater-or-equal and unsigned less-or-equal, in that order.
- R4: A taken branch gives `res_next_pc` = `br_pc` + 2 + 2 × (the 10-bit `br_ofs` sign-extended), modulo 2^32.
- R5: A legal branch that is not taken gives `res_next_pc` = `br_pc` + 2.
- R6: Condition codes 10 to 15 set `res_illegal`, clear `res_taken` and give `res_next_pc` = `br_pc`. Legal codes clear `res_illegal`.
- R7: When a compare and a branch arrive in the same cycle, the branch uses the operands stored before that cycle. The new operands apply from the next branch on.
- R8: Results are registered. `res_valid` is high exactly in the cycle after a cycle with `br_valid` high. In cycles without a result, `res_taken`, `res_illegal` and `res_next_pc` keep their last values.
- R9: The displacement field covers its full range: 0x1FF gives +1022 bytes past `br_pc` + 2 and 0x200 gives −1024 bytes. Sums past either end of the 32-bit address space wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_valid | input | 1 | Compare strobe: store the two operands |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | Branch strobe: resolve a branch |
| br_cond | input | 4 | Condition code |
| br_ofs | input | 10 | Signed displacement in instruction halfwords |
| br_pc | input | 32 | Address of the branch instruction |
| res_valid | output | 1 | Result present this cycle |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 32 | Address of the next instruction |
| res_illegal | output | 1 | Condition code not defined |

## Verification
The sweep pairs every condition code with operands that straddle the sign boundary: 0x7FFFFFFF against 0x80000000, and all-ones against zero or one. A design that swapped the signed and unsigned compares, or swapped the operand order, gives the wrong taken flag on exactly these pairs. Every displacement value is applied, so an offset that is zero-extended, not doubled, or added to the branch address without the +2 shows up as a wrong target, mainly at 0x1FF, 0x200 and at address wraparound. A compare issued together with a branch catches a design that forwards the new operands. The undefined codes catch a design that falls through to some relation or to the sequential address.

// File: rtl/brcmp_pkg.sv
// Package: shared condition-code encoding and fixed widths of the
// compare-latch branch unit. Assumes 4-bit condition codes.
package brcmp_pkg;

    localparam int COND_W   = 4;
    localparam int NUM_COND = 10;
    localparam int COND_SPACE = 1 << COND_W;

    typedef enum logic [COND_W-1:0] {
        BC_EQ  = 4'd0,
        BC_NE  = 4'd1,
        BC_SLT = 4'd2,
        BC_SGT = 4'd3,
        BC_ULT = 4'd4,
        BC_UGT = 4'd5,
        BC_SGE = 4'd6,
        BC_SLE = 4'd7,
        BC_UGE = 4'd8,
        BC_ULE = 4'd9
    } bcond_e;

endpackage

// File: rtl/opnd_store.sv
// Operand latch pair: records the two operands of the most recent compare.
// Assumes synchronous active-low reset; a load is visible from the next cycle.
module opnd_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic [DATA_W-1:0] lat_a,
    output logic [DATA_W-1:0] lat_b
);

    // Capture both operands on a compare strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_a <= '0;
            lat_b <= '0;
        end else if (load) begin
            lat_a <= in_a;
            lat_b <= in_b;
        end
    end

endmodule

// File: rtl/cond_eval.sv
// Condition evaluator: computes equality, signed-less and unsigned-less of
// the stored operands (first against second), then picks the relation named
// by the condition code. Codes at or above NUM_COND are illegal and never
// taken. Purely combinational.
module cond_eval
    import brcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [COND_W-1:0] cond,
    output logic              take,
    output logic              illegal
);

    logic                  is_eq;
    logic                  is_slt;
    logic                  is_ult;
    logic [COND_SPACE-1:0] rel;

    // Three base relations from which all ten conditions follow.
    always_comb begin
        is_eq  = (op_a == op_b);
        is_slt = ($signed(op_a) < $signed(op_b));
        is_ult = (op_a < op_b);
    end

    // Relation vector indexed by the defined condition codes.
    always_comb begin
        rel[BC_EQ]  = is_eq;
        rel[BC_NE]  = !is_eq;
        rel[BC_SLT] = is_slt;
        rel[BC_SGT] = !is_slt && !is_eq;
        rel[BC_ULT] = is_ult;
        rel[BC_UGT] = !is_ult && !is_eq;
        rel[BC_SGE] = !is_slt;
        rel[BC_SLE] = is_slt || is_eq;
        rel[BC_UGE] = !is_ult;
        rel[BC_ULE] = is_ult || is_eq;
    end

    // Undefined codes map to a never-taken relation.
    genvar gi;
    generate
        for (gi = NUM_COND; gi < COND_SPACE; gi++) begin : g_undef
            assign rel[gi] = 1'b0;
        end
    endgenerate

    // Select the named relation and flag undefined codes.
    always_comb begin
        illegal = (int'(cond) >= NUM_COND);
        take    = rel[cond];
    end

endmodule

// File: rtl/tgt_calc.sv
// Target calculator: forms the sequential address (branch address plus one
// instruction) and the displaced target (sequential address plus the
// sign-extended offset scaled by the instruction size). Assumes a
// power-of-two instruction size of INSN_BYTES. Combinational.
module tgt_calc #(
    parameter int ADDR_W     = 32,
    parameter int OFS_W      = 10,
    parameter int INSN_BYTES = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] jump_pc
);

    localparam int SHIFT = $clog2(INSN_BYTES);
    localparam int EXT_W = ADDR_W - OFS_W - SHIFT;

    logic [ADDR_W-1:0] disp;

    // Scaled, sign-extended displacement and both candidate addresses.
    always_comb begin
        disp    = {{EXT_W{ofs[OFS_W-1]}}, ofs, {SHIFT{1'b0}}};
        seq_pc  = pc + ADDR_W'(INSN_BYTES);
        jump_pc = seq_pc + disp;
    end

endmodule

// File: rtl/cmp_branch_unit.sv
// Top level of the compare-latch branch unit. A compare strobe records the
// two operands; a branch strobe evaluates a condition against the stored
// operands and registers taken flag, next address and illegal flag, valid
// one cycle later. A compare in the same cycle as a branch affects only
// later branches. Synchronous active-low reset.
module cmp_branch_unit
    import brcmp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int OFS_W      = 10,
    parameter int INSN_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              br_valid,
    input  logic [COND_W-1:0] br_cond,
    input  logic [OFS_W-1:0]  br_ofs,
    input  logic [ADDR_W-1:0] br_pc,
    output logic              res_valid,
    output logic              res_taken,
    output logic [ADDR_W-1:0] res_next_pc,
    output logic              res_illegal
);

    logic [DATA_W-1:0] lat_a;
    logic [DATA_W-1:0] lat_b;
    logic              take;
    logic              bad_cond;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] jump_pc;
    logic [ADDR_W-1:0] nxt_pc;

    opnd_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmp_valid),
        .in_a  (cmp_a),
        .in_b  (cmp_b),
        .lat_a (lat_a),
        .lat_b (lat_b)
    );

    cond_eval #(.DATA_W(DATA_W)) u_eval (
        .op_a    (lat_a),
        .op_b    (lat_b),
        .cond    (br_cond),
        .take    (take),
        .illegal (bad_cond)
    );

    tgt_calc #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_tgt (
        .pc      (br_pc),
        .ofs     (br_ofs),
        .seq_pc  (seq_pc),
        .jump_pc (jump_pc)
    );

    // Choose the next address: faulting branch address, target or fall-through.
    always_comb begin
        if (bad_cond)  nxt_pc = br_pc;
        else if (take) nxt_pc = jump_pc;
        else           nxt_pc = seq_pc;
    end

    // Result strobe: one pulse per branch.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= br_valid;
    end

    // Result payload: loaded on a branch, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_taken   <= 1'b0;
            res_illegal <= 1'b0;
            res_next_pc <= '0;
        end else if (br_valid) begin
            res_taken   <= take && !bad_cond;
            res_illegal <= bad_cond;
            res_next_pc <= nxt_pc;
        end
    end

endmodule

// File: rtl/cmp_branch_unit_chk.sv
// Checker for cmp_branch_unit: relates result ports to the branch inputs
// of the previous cycle. Bound into every instance of the top module.
module cmp_branch_unit_chk
    import brcmp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_valid,
    input logic [COND_W-1:0] br_cond,
    input logic [ADDR_W-1:0] br_pc,
    input logic              res_valid,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_next_pc,
    input logic              res_illegal
);

    logic was_run;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) was_run <= 1'b0;
        else        was_run <= 1'b1;
    end

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        was_run |-> (res_valid == $past(br_valid)));

    assert_hold_payload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && !res_valid) |-> ($stable(res_next_pc) && $stable(res_taken) && $stable(res_illegal)));

    assert_illegal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && res_valid) |-> (res_illegal == (int'($past(br_cond)) >= NUM_COND)));

    assert_illegal_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_illegal) |-> (!res_taken && res_next_pc == $past(br_pc)));

    assert_fall_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && res_valid && !res_taken && !res_illegal)
            |-> (res_next_pc == $past(br_pc) + ADDR_W'(INSN_BYTES)));

endmodule

bind cmp_branch_unit cmp_branch_unit_chk #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid    (br_valid),
    .br_cond     (br_cond),
    .br_pc       (br_pc),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_next_pc (res_next_pc),
    .res_illegal (res_illegal)
);

// File: tb/test_cmp_branch_unit.sv
module test_cmp_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_valid;
    logic [31:0] cmp_a, cmp_b;
    logic        br_valid;
    logic [3:0]  br_cond;
    logic [9:0]  br_ofs;
    logic [31:0] br_pc;
    logic        res_valid, res_taken, res_illegal;
    logic [31:0] res_next_pc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cmp_branch_unit i_cmp_branch_unit (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .br_valid(br_valid), .br_cond(br_cond), .br_ofs(br_ofs), .br_pc(br_pc),
        .res_valid(res_valid), .res_taken(res_taken),
        .res_next_pc(res_next_pc), .res_illegal(res_illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_taken(input int c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            0: return a == b;
            1: return a != b;
            2: return $signed(a) <  $signed(b);
            3: return $signed(a) >  $signed(b);
            4: return a <  b;
            5: return a >  b;
            6: return $signed(a) >= $signed(b);
            7: return $signed(a) <= $signed(b);
            8: return a >= b;
            9: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ref_target(input logic [31:0] pc, input int ofs);
        int s;
        s = (ofs >= 512) ? ofs - 1024 : ofs;
        return pc + 32'd2 + 32'(s * 2);
    endfunction

    task automatic do_compare(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_a = a; cmp_b = b;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    // Issue one branch and check all outputs one cycle later.
    task automatic do_branch(input string req, input int c, input int ofs,
                             input logic [31:0] pc, input logic [31:0] a,
                             input logic [31:0] b);
        bit t, ill;
        logic [31:0] nx;
        @(negedge clk);
        br_valid = 1'b1; br_cond = 4'(c); br_ofs = 10'(ofs); br_pc = pc;
        @(negedge clk);
        br_valid = 1'b0;
        ill = (c >= 10);
        t   = ill ? 1'b0 : ref_taken(c, a, b);
        nx  = ill ? pc : (t ? ref_target(pc, ofs) : pc + 32'd2);
        check(req, "valid",   32'(res_valid),   32'd1);
        check(req, "taken",   32'(res_taken),   32'(t));
        check(req, "illegal", 32'(res_illegal), 32'(ill));
        check(req, "next_pc", res_next_pc,      nx);
    endtask

    logic [31:0] vals [6];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h0000_0005;
        rst_n = 1'b0; cmp_valid = 1'b0; cmp_a = '0; cmp_b = '0;
        br_valid = 1'b0; br_cond = '0; br_ofs = '0; br_pc = '0;
        repeat (3) @(negedge clk);
        // R1: reset state on outputs
        check("R1", "valid",   32'(res_valid),   32'd0);
        check("R1", "taken",   32'(res_taken),   32'd0);
        check("R1", "illegal", 32'(res_illegal), 32'd0);
        check("R1", "next_pc", res_next_pc,      32'd0);
        rst_n = 1'b1;
        // R1: latches are zero: EQ is taken, ULT not taken
        do_branch("R1", 0, 3, 32'h100, 32'd0, 32'd0);
        do_branch("R1", 4, 3, 32'h100, 32'd0, 32'd0);

        // R2 R3 R5 R6: all operand pairs, all 16 codes
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                do_compare(vals[i], vals[j]);
                for (int c = 0; c < 16; c++) begin
                    do_branch(c < 10 ? "R3" : "R6", c, 37 + c, 32'h0000_4000 + 32'(c*16),
                              vals[i], vals[j]);
                end
            end
        end

        // R4 R9: every offset on a taken EQ branch, plus wraparound
        do_compare(32'd9, 32'd9);
        for (int o = 0; o < 1024; o++) begin
            do_branch(o == 511 || o == 512 ? "R9" : "R4", 0, o, 32'h0001_0000, 32'd9, 32'd9);
        end
        do_branch("R9", 0, 511, 32'hFFFF_FFFE, 32'd9, 32'd9);
        do_branch("R9", 0, 512, 32'h0000_0010, 32'd9, 32'd9);

        // R8: outputs hold in a cycle without a branch
        @(negedge clk);
        check("R8", "valid_idle", 32'(res_valid), 32'd0);
        check("R8", "hold_pc",    res_next_pc,    ref_target(32'h0000_0010, 512));
        check("R8", "hold_taken", 32'(res_taken), 32'd1);

        // R7: compare and branch in the same cycle use old operands
        do_compare(32'd1, 32'd2);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_a = 32'd7; cmp_b = 32'd7;
        br_valid = 1'b1; br_cond = 4'd0; br_ofs = 10'd4; br_pc = 32'h200;
        @(negedge clk);
        cmp_valid = 1'b0; br_valid = 1'b0;
        check("R7", "old_taken", 32'(res_taken), 32'd0);
        check("R7", "old_pc",    res_next_pc,    32'h202);
        do_branch("R7", 0, 4, 32'h200, 32'd7, 32'd7);

        // R2: no compare strobe leaves latches unchanged
        @(negedge clk);
        cmp_a = 32'd1; cmp_b = 32'd0;
        do_branch("R2", 0, 4, 32'h300, 32'd7, 32'd7);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule